// File: doc/BRIEF.md
# Length-Agnostic Loop Predicate Generator

This block produces the per-lane mask that governs one pass of a vector loop. The vector width is a build-time parameter. Each request gives a signed 64-bit start index, a signed 64-bit bound, an element-size code and a step-size code. One cycle later the block returns four results and an advanced index:

- a mask with one bit per vector byte,
- the number of active elements,
- a flag saying that the lowest element is active, which serves as the loop-continue condition,
- a flag saying that no element is active.

The advanced index is the start index plus the number of elements of the chosen step size that fit in one vector.

Loop control does not need a separate remainder pass. When fewer elements remain than fit in a vector, only the leading remaining lanes are enabled. Because the mask is kept at byte granularity, an element wider than a byte owns a group of mask bits, and only the lowest bit of each group is set. A constant output reports the vector length in bytes, so software can size its strides.

Top module: `vl_pred_gen`

## Requirements
- R1: `vl_bytes_o` always equals VLEN_BITS/8. VLEN_BITS may be any multiple of 128 from 128 to 2048.
- R2: The element size is coded as 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit, which gives N = VLEN_BITS/8 >> code elements per vector. Element k (0 <= k < N) is active exactly when start + k < bound, compared as signed 64-bit values without overflow.
- R3: If the remaining count (bound - start) is positive and smaller than N, exactly that many leading elements are active. If it is N or more, all N elements are active.
- R4: For an active element k of code e, mask bit k·2^e is set. Every other bit in that element's byte group is 0.
- R5: `act_cnt_o` equals the number of active elements, which is also the number of set mask bits.
- R6: `first_o` is 1 exactly when element 0 is active, and it acts as the continue flag.
- R7: `none_o` is 1 exactly when no element is active. A bound at or below the start index gives an all-zero mask, a count of 0, `first_o`=0 and `none_o`=1.
- R8: `next_idx_o` equals the start index plus (VLEN_BITS/8 >> step code), modulo 2^64. The step code uses the same encoding as the element size, so code 2 adds VLEN_BITS/32.
- R9: Every result is registered. `out_valid_o` is high exactly in the cycle after `in_valid_i` is high. While `in_valid_i` is low, the mask, count, flags and next index hold their last values.
- R10: After reset, `out_valid_o`=0, the mask is 0, the count is 0, `first_o`=0, `none_o`=1 and `next_idx_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request strobe |
| start_i | input | 64 | Signed start index |
| bound_i | input | 64 | Signed exclusive bound |
| esize_i | input | 2 | Element-size code |
| step_i | input | 2 | Step-size code for the index advance |
| out_valid_o | output | 1 | Result valid |
| pred_o | output | VLEN_BITS/8 | Byte-granular lane mask |
| act_cnt_o | output | $clog2(VLEN_BITS/8+1) | Active element count |
| first_o | output | 1 | Lowest element active (continue) |
| none_o | output | 1 | No element active |
| next_idx_o | output | 64 | Advanced index |
| vl_bytes_o | output | $clog2(VLEN_BITS/8+1) | Vector length in bytes |

## Verification
The bench concentrates on the edges of the remaining count:

- **Exactly N-1, N and N+1 elements left, for every size code.** A design that used `<=` in place of `<` would enable one extra lane and overcount.
- **Bound equal to the start, bound below the start, and start near the signed limits.** A subtraction that wraps would show up here as spurious full masks on empty loops.
- **Element sizes wider than a byte.** Setting the top bit of a group instead of the bottom one, or filling the whole group, breaks the mask pattern. Mixing up the step code with the size code gives a wrong next index.
- **Idle cycles between requests.** These catch results that change without a request.

// File: rtl/vl_pred_gen.sv
module vl_pred_gen #(
  parameter int VLEN_BITS = 256,
  parameter int IDX_W     = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid_i,
  input  logic [IDX_W-1:0]                   start_i,
  input  logic [IDX_W-1:0]                   bound_i,
  input  logic [1:0]                         esize_i,
  input  logic [1:0]                         step_i,
  output logic                               out_valid_o,
  output logic [VLEN_BITS/8-1:0]             pred_o,
  output logic [$clog2(VLEN_BITS/8+1)-1:0]   act_cnt_o,
  output logic                               first_o,
  output logic                               none_o,
  output logic [IDX_W-1:0]                   next_idx_o,
  output logic [$clog2(VLEN_BITS/8+1)-1:0]   vl_bytes_o
);
  localparam int VB = VLEN_BITS / 8;
  localparam int CW = $clog2(VB + 1);

  logic signed [IDX_W:0] span, lanes_ext;
  logic [CW-1:0]         lanes, cnt_d;
  logic [VB-1:0]         pred_d;
  logic [IDX_W-1:0]      next_d;
  logic [1:0]            esz_q;

  assign vl_bytes_o = CW'(VB);
  assign span       = $signed({bound_i[IDX_W-1], bound_i}) - $signed({start_i[IDX_W-1], start_i});
  assign lanes      = CW'(VB >> esize_i);
  assign lanes_ext  = $signed({{(IDX_W+1-CW){1'b0}}, lanes});
  assign next_d     = start_i + IDX_W'(VB >> step_i);

  always_comb begin
    if (span <= 0)               cnt_d = '0;
    else if (span >= lanes_ext)  cnt_d = lanes;
    else                         cnt_d = span[CW-1:0];
  end

  always_comb begin
    for (int j = 0; j < VB; j++) begin
      int e;
      e = int'(esize_i);
      pred_d[j] = ((j % (1 << e)) == 0) && ((j >> e) < int'(cnt_d));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      pred_o      <= '0;
      act_cnt_o   <= '0;
      first_o     <= 1'b0;
      none_o      <= 1'b1;
      next_idx_o  <= '0;
      esz_q       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        pred_o     <= pred_d;
        act_cnt_o  <= cnt_d;
        first_o    <= (cnt_d != '0);
        none_o     <= (cnt_d == '0);
        next_idx_o <= next_d;
        esz_q      <= esize_i;
      end
    end
  end

  logic [VB-1:0] grp_mask;
  always_comb begin
    for (int j = 0; j < VB; j++) grp_mask[j] = (j % (1 << int'(esz_q))) == 0;
  end

  a_r4_group_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_o & ~grp_mask) == '0);
  a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pred_o) == int'(act_cnt_o));
  a_r6_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
    first_o == pred_o[0]);
  a_r7_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
    none_o == (pred_o == '0));
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(pred_o) && $stable(next_idx_o) && !out_valid_o);
  a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_cnt_o) <= (VB >> esz_q));
endmodule

// File: tb/vl_pred_gen_tb_top.sv
`timescale 1ns/1ps
module vl_pred_gen_tb_top;
  localparam int VLEN = 256;
  localparam int VB   = VLEN / 8;
  localparam int CW   = $clog2(VB + 1);

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [63:0] start_v = 0, bound_v = 0;
  logic [1:0]  esz = 0, stp = 0;
  logic out_valid, first, none;
  logic [VB-1:0] pred;
  logic [CW-1:0] cnt, vlb;
  logic [63:0] nidx;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vl_pred_gen #(.VLEN_BITS(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .start_i(start_v),
    .bound_i(bound_v), .esize_i(esz), .step_i(stp), .out_valid_o(out_valid),
    .pred_o(pred), .act_cnt_o(cnt), .first_o(first), .none_o(none),
    .next_idx_o(nidx), .vl_bytes_o(vlb));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VB-1:0] exp_pred(logic [63:0] s, logic [63:0] b, int e);
    logic [VB-1:0] m = '0;
    for (int k = 0; k < (VB >> e); k++)
      if ($signed({s[63], s}) + 65'(k) < $signed({b[63], b})) m[k * (1 << e)] = 1'b1;
    return m;
  endfunction

  task automatic run(logic [63:0] s, logic [63:0] b, logic [1:0] e, logic [1:0] st);
    logic [VB-1:0] ep;
    int ec;
    @(negedge clk);
    start_v = s; bound_v = b; esz = e; stp = st; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    ep = exp_pred(s, b, int'(e));
    ec = $countones(ep);
    chk("R9 valid", 64'(out_valid), 64'd1);
    chk("R2/R4 pred", 64'(pred), 64'(ep));
    chk("R3/R5 count", 64'(cnt), 64'(ec));
    chk("R6 first", 64'(first), 64'(ep[0]));
    chk("R7 none", 64'(none), 64'(ec == 0));
    chk("R8 next", nidx, s + 64'(VB >> st));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VB-1:0] hp;
    logic [63:0]   hn;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R10 valid", 64'(out_valid), 0);
    chk("R10 pred", 64'(pred), 0);
    chk("R10 count", 64'(cnt), 0);
    chk("R10 first", 64'(first), 0);
    chk("R10 none", 64'(none), 1);
    chk("R10 next", nidx, 0);
    rst_n = 1;
    chk("R1 vl bytes", 64'(vlb), 64'(VB));
    for (int e = 0; e < 4; e++) begin
      int n = VB >> e;
      run(64'd100, 64'd100 + 64'(n - 1), 2'(e), 2'(e));
      run(64'd100, 64'd100 + 64'(n), 2'(e), 2'd2);
      run(64'd100, 64'd100 + 64'(n + 1), 2'(e), 2'd0);
      run(64'd7, 64'd8, 2'(e), 2'd3);
      run(64'd50, 64'd50, 2'(e), 2'd1);
      run(64'd50, 64'd20, 2'(e), 2'd2);
      run(-64'sd3, 64'd2, 2'(e), 2'd2);
      run(64'h7FFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000, 2'(e), 2'd0);
      run(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'(e), 2'd1);
    end
    run(64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd0);
    hp = pred; hn = nidx;
    @(negedge clk);
    start_v = 64'd0; bound_v = 64'd1000; esz = 0; stp = 0;
    @(negedge clk);
    chk("R9 hold valid", 64'(out_valid), 0);
    chk("R9 hold pred", 64'(pred), 64'(hp));
    chk("R9 hold next", nidx, hn);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] s, b;
      s = {$urandom, $urandom};
      if ($urandom_range(3) == 0) b = {$urandom, $urandom};
      else b = s + 64'($urandom_range(VB + 4)) - 64'd2;
      run(s, b, 2'($urandom_range(3)), 2'($urandom_range(3)));
    end
    chk("R1 vl bytes end", 64'(vlb), 64'(VB));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule